// File: doc/BRIEF.md
# Shared Receive/Transmit Radio Frame Store

This block is a 128-byte, single-port byte store shared by three users of a short-range packet radio. A demodulator pushes a received frame into it. A host processor reads and writes any byte at random, one access per cycle with no wait states. A transmit streamer reads a prepared frame back out to the modulator. Only one frame is held at a time, and the receive and transmit layouts differ. A received frame keeps its PHY length in a separate register. Its payload starts at byte 0, and a link-quality byte follows the last stored payload byte. A transmit frame carries its length in byte 0, and its payload starts at byte 1.

Only one of the three users reaches the storage port in a given cycle. Receive writes come first, transmit reads second and host accesses last. A host access that loses arbitration sees a busy flag for that cycle and must be presented again. An optional protection mode locks a completed received frame. A frame that arrives while the lock is held is dropped whole and recorded in a sticky overrun flag. A pulse on a clear input releases the lock.

Top module: `rfbuf_top`

## Requirements
- R1: After reset, host_busy, tx_busy, tx_valid, rx_active, rx_done, rx_locked, rx_overrun and rx_len_err are 0, and rx_frame_len and host_rdata are 0.
- R2: A host access is performed in a cycle where host_en is 1 and host_busy is 0 (host_we=1 writes, host_we=0 reads). Read data appears on host_rdata in the next cycle and holds until the next performed read.
- R3: With host_from_end=0, host_idx selects byte host_idx. With host_from_end=1, it selects byte 127-host_idx.
- R4: rx_sof latches rx_len into rx_frame_len, and the length byte is not stored. The payload bytes given with rx_valid are stored in order from byte 0, and rx_active is 1 from rx_sof until the quality byte.
- R5: The byte given with rx_lqi_valid is stored right after the last stored payload byte. rx_done is 1 for exactly the next cycle.
- R6: If rx_len exceeds 127, only the first 127 payload bytes are stored, the quality byte goes to byte 127, and rx_len_err becomes 1. rx_len_err is reloaded at each accepted rx_sof.
- R7: When prot_en is 1 as a frame completes, rx_locked becomes 1. An rx_sof that arrives while rx_locked and prot_en are both 1 drops that frame: nothing is stored, rx_frame_len is unchanged and rx_overrun becomes 1. A prot_clr pulse clears rx_locked and rx_overrun.
- R8: In a cycle with a receive write, any host access gets host_busy=1 and is not performed. It completes in a later cycle if it is presented again.
- R9: A tx_go pulse while tx_busy=0 reads byte 0 as L, capped at 127. It then emits bytes 1..L in order, one per tx_valid pulse, with tx_last on the final byte. L=0 emits nothing. tx_busy is 1 from the cycle after tx_go until the streamer is idle again.
- R10: Stored bytes change only through receive writes and host writes. Transmit streaming leaves the contents intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_en | input | 1 | Host access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_from_end | input | 1 | 1 = address is counted back from byte 127 |
| host_idx | input | 7 | Byte index |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid the cycle after a performed read |
| host_busy | output | 1 | Host access not performed this cycle |
| rx_sof | input | 1 | Start of received frame, with rx_len |
| rx_len | input | 8 | PHY length of the received frame |
| rx_valid | input | 1 | Received payload byte strobe |
| rx_data | input | 8 | Received payload byte |
| rx_lqi_valid | input | 1 | Quality byte strobe, ends the frame |
| rx_lqi | input | 8 | Link quality byte |
| prot_en | input | 1 | Enable the overwrite lock |
| prot_clr | input | 1 | Release the lock and clear the overrun flag |
| rx_frame_len | output | 8 | Latched received length |
| rx_active | output | 1 | A frame is being stored |
| rx_done | output | 1 | One-cycle pulse after the quality byte |
| rx_locked | output | 1 | Stored frame is protected |
| rx_overrun | output | 1 | Sticky: a frame was dropped by the lock |
| rx_len_err | output | 1 | Last accepted length exceeded 127 |
| tx_go | input | 1 | Start streaming the stored transmit frame |
| tx_busy | output | 1 | Streamer active |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of the transmit frame |

## Verification
A receive write and a host access can fall in the same cycle and compete for the single storage port. To provoke this, a 60-byte received frame with idle gaps runs in parallel with a burst of random host writes. The bench retries each access that sees host_busy and records its model write only in the cycle where the access is performed. Judgement comes from a full readback of all 128 bytes against that cycle-ordered model, together with a check that busy cycles actually occurred.

// File: rtl/rfbuf_pkg.sv
package rfbuf_pkg;
  localparam int FB_DEPTH = 128;
  localparam int FB_DW    = 8;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_LEN  = 2'd1,
    TX_DATA = 2'd2
  } tx_state_e;
endpackage

// File: rtl/rfbuf_rstsync.sv
module rfbuf_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/rfbuf_mem.sv
module rfbuf_mem #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store_q[addr] <= wdata;
  end

  assign rdata = store_q[addr];
endmodule

// File: rtl/rfbuf_host.sv
module rfbuf_host #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_sn,
  input  logic          en,
  input  logic          we,
  input  logic          from_end,
  input  logic [AW-1:0] idx,
  input  logic          port_taken,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] addr,
  output logic          gnt,
  output logic          busy,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] rdata_q, rdata_d;
  logic          rd_load;

  assign addr    = from_end ? (AW'(DEPTH - 1) - idx) : idx;
  assign gnt     = en & ~port_taken;
  assign busy    = en & port_taken;
  assign rd_load = gnt & ~we;

  always_comb begin
    rdata_d = rdata_q;
    if (rd_load) rdata_d = mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) rdata_q <= '0;
    else         rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

  // R2
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    $past(!rd_load) |-> $stable(rdata_q));

  // R8
  busy_gnt_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    en |-> (busy != gnt));
endmodule

// File: rtl/rfbuf_rx.sv
module rfbuf_rx #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_sn,
  input  logic          sof,
  input  logic [DW-1:0] len,
  input  logic          valid,
  input  logic [DW-1:0] data,
  input  logic          lqi_valid,
  input  logic [DW-1:0] lqi,
  input  logic          prot_en,
  input  logic          prot_clr,
  output logic          we,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wdata,
  output logic [DW-1:0] frame_len,
  output logic          active,
  output logic          done,
  output logic          locked,
  output logic          overrun,
  output logic          len_err
);
  localparam logic [AW-1:0] CAP = AW'(DEPTH - 1);

  logic          active_q, active_d;
  logic          drop_q, drop_d;
  logic          done_q, done_d;
  logic          lock_q, lock_d;
  logic          ovr_q, ovr_d;
  logic          lerr_q, lerr_d;
  logic [DW-1:0] flen_q, flen_d;
  logic [AW-1:0] lim_q, lim_d;
  logic [AW-1:0] wptr_q, wptr_d;
  logic          blocked, too_long, data_wr, lqi_wr;

  assign blocked  = lock_q & prot_en;
  assign too_long = len > DW'(DEPTH - 1);
  assign data_wr  = active_q & ~sof & valid & (wptr_q < lim_q);
  assign lqi_wr   = active_q & ~sof & lqi_valid;

  always_comb begin
    active_d = active_q;
    drop_d   = drop_q;
    lock_d   = lock_q;
    ovr_d    = ovr_q;
    lerr_d   = lerr_q;
    flen_d   = flen_q;
    lim_d    = lim_q;
    wptr_d   = wptr_q;
    done_d   = 1'b0;
    if (prot_clr) begin
      lock_d = 1'b0;
      ovr_d  = 1'b0;
    end
    if (sof) begin
      if (blocked) begin
        ovr_d    = 1'b1;
        drop_d   = 1'b1;
        active_d = 1'b0;
      end else begin
        active_d = 1'b1;
        drop_d   = 1'b0;
        flen_d   = len;
        lerr_d   = too_long;
        lim_d    = too_long ? CAP : len[AW-1:0];
        wptr_d   = '0;
      end
    end else if (lqi_wr) begin
      active_d = 1'b0;
      done_d   = 1'b1;
      if (prot_en) lock_d = 1'b1;
    end else if (data_wr) begin
      wptr_d = wptr_q + 1'b1;
    end else if (drop_q & lqi_valid) begin
      drop_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      active_q <= 1'b0;
      drop_q   <= 1'b0;
      done_q   <= 1'b0;
      lock_q   <= 1'b0;
      ovr_q    <= 1'b0;
      lerr_q   <= 1'b0;
      flen_q   <= '0;
      lim_q    <= '0;
      wptr_q   <= '0;
    end else begin
      active_q <= active_d;
      drop_q   <= drop_d;
      done_q   <= done_d;
      lock_q   <= lock_d;
      ovr_q    <= ovr_d;
      lerr_q   <= lerr_d;
      flen_q   <= flen_d;
      lim_q    <= lim_d;
      wptr_q   <= wptr_d;
    end
  end

  assign we        = data_wr | lqi_wr;
  assign addr      = wptr_q;
  assign wdata     = lqi_wr ? lqi : data;
  assign frame_len = flen_q;
  assign active    = active_q;
  assign done      = done_q;
  assign locked    = lock_q;
  assign overrun   = ovr_q;
  assign len_err   = lerr_q;

  // R7
  drop_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    drop_q |-> !we);

  // R7
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (sof && blocked) |=> (overrun && $stable(frame_len)));

  // R6
  len_err_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (sof && !blocked && too_long) |=> len_err);

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    done |-> !$past(done));

  // R6
  wptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    data_wr |-> (addr < CAP));
endmodule

// File: rtl/rfbuf_tx.sv
module rfbuf_tx
  import rfbuf_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_sn,
  input  logic          go,
  input  logic          gnt,
  input  logic [DW-1:0] rdata,
  output logic          req,
  output logic [AW-1:0] addr,
  output logic          valid,
  output logic [DW-1:0] data,
  output logic          last,
  output logic          busy
);
  localparam logic [AW-1:0] CAP = AW'(DEPTH - 1);

  tx_state_e     state_q, state_d;
  logic [AW-1:0] idx_q, idx_d;
  logic [AW-1:0] len_q, len_d;
  logic          valid_q, valid_d;
  logic [DW-1:0] data_q, data_d;
  logic          last_q, last_d;
  logic [AW-1:0] len_cap;

  assign len_cap = (rdata > DW'(DEPTH - 1)) ? CAP : rdata[AW-1:0];

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    len_d   = len_q;
    valid_d = 1'b0;
    data_d  = data_q;
    last_d  = 1'b0;
    unique case (state_q)
      TX_IDLE: if (go) state_d = TX_LEN;
      TX_LEN: if (gnt) begin
        len_d = len_cap;
        idx_d = AW'(1);
        state_d = (len_cap == '0) ? TX_IDLE : TX_DATA;
      end
      TX_DATA: if (gnt) begin
        valid_d = 1'b1;
        data_d  = rdata;
        last_d  = (idx_q == len_q);
        if (idx_q == len_q) state_d = TX_IDLE;
        else                idx_d = idx_q + 1'b1;
      end
      default: state_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= TX_IDLE;
      idx_q   <= '0;
      len_q   <= '0;
      valid_q <= 1'b0;
      data_q  <= '0;
      last_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      len_q   <= len_d;
      valid_q <= valid_d;
      data_q  <= data_d;
      last_q  <= last_d;
    end
  end

  assign req   = (state_q != TX_IDLE);
  assign addr  = (state_q == TX_LEN) ? '0 : idx_q;
  assign busy  = req;
  assign valid = valid_q;
  assign data  = data_q;
  assign last  = last_q;

  // R9
  tx_valid_src_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    valid |-> $past(gnt));

  // R9
  tx_last_idle_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (valid && last) |-> !busy);

  // R9
  tx_last_valid_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    last |-> valid);
endmodule

// File: rtl/rfbuf_top.sv
module rfbuf_top #(
  parameter int DEPTH = rfbuf_pkg::FB_DEPTH,
  parameter int DW    = rfbuf_pkg::FB_DW,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_en,
  input  logic          host_we,
  input  logic          host_from_end,
  input  logic [AW-1:0] host_idx,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          host_busy,
  input  logic          rx_sof,
  input  logic [DW-1:0] rx_len,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_lqi_valid,
  input  logic [DW-1:0] rx_lqi,
  input  logic          prot_en,
  input  logic          prot_clr,
  output logic [DW-1:0] rx_frame_len,
  output logic          rx_active,
  output logic          rx_done,
  output logic          rx_locked,
  output logic          rx_overrun,
  output logic          rx_len_err,
  input  logic          tx_go,
  output logic          tx_busy,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  output logic          tx_last
);
  logic          rst_sn;
  logic          rx_we;
  logic [AW-1:0] rx_addr;
  logic [DW-1:0] rx_wdata;
  logic          tx_req, tx_gnt;
  logic [AW-1:0] tx_addr;
  logic          h_gnt;
  logic [AW-1:0] h_addr;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  rfbuf_rstsync u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  rfbuf_rx #(.DEPTH(DEPTH), .DW(DW)) u_rx (
    .clk(clk), .rst_sn(rst_sn),
    .sof(rx_sof), .len(rx_len), .valid(rx_valid), .data(rx_data),
    .lqi_valid(rx_lqi_valid), .lqi(rx_lqi),
    .prot_en(prot_en), .prot_clr(prot_clr),
    .we(rx_we), .addr(rx_addr), .wdata(rx_wdata),
    .frame_len(rx_frame_len), .active(rx_active), .done(rx_done),
    .locked(rx_locked), .overrun(rx_overrun), .len_err(rx_len_err)
  );

  rfbuf_tx #(.DEPTH(DEPTH), .DW(DW)) u_tx (
    .clk(clk), .rst_sn(rst_sn), .go(tx_go), .gnt(tx_gnt),
    .rdata(mem_rdata), .req(tx_req), .addr(tx_addr),
    .valid(tx_valid), .data(tx_data), .last(tx_last), .busy(tx_busy)
  );

  rfbuf_host #(.DEPTH(DEPTH), .DW(DW)) u_host (
    .clk(clk), .rst_sn(rst_sn),
    .en(host_en), .we(host_we), .from_end(host_from_end), .idx(host_idx),
    .port_taken(rx_we | tx_req), .mem_rdata(mem_rdata),
    .addr(h_addr), .gnt(h_gnt), .busy(host_busy), .rdata(host_rdata)
  );

  // Fixed priority on the single port: receive write, transmit read, host.
  assign tx_gnt = tx_req & ~rx_we;

  always_comb begin
    mem_we    = 1'b0;
    mem_addr  = h_addr;
    mem_wdata = host_wdata;
    if (rx_we) begin
      mem_we    = 1'b1;
      mem_addr  = rx_addr;
      mem_wdata = rx_wdata;
    end else if (tx_req) begin
      mem_addr  = tx_addr;
    end else if (h_gnt) begin
      mem_we    = host_we;
    end
  end

  rfbuf_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk(clk), .we(mem_we), .addr(mem_addr),
    .wdata(mem_wdata), .rdata(mem_rdata)
  );

  // R8
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    $onehot0({rx_we, tx_gnt, h_gnt}));

  // R8
  busy_on_rx_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (host_en && rx_we) |-> host_busy);

  // R10
  write_src_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    mem_we |-> (rx_we || (h_gnt && host_we)));
endmodule

// File: tb/sim_rfbuf_top.sv
module sim_rfbuf_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       host_en, host_we, host_from_end;
  logic [6:0] host_idx;
  logic [7:0] host_wdata, host_rdata;
  logic       host_busy;
  logic       rx_sof, rx_valid, rx_lqi_valid, prot_en, prot_clr;
  logic [7:0] rx_len, rx_data, rx_lqi, rx_frame_len, tx_data;
  logic       rx_active, rx_done, rx_locked, rx_overrun, rx_len_err;
  logic       tx_go, tx_busy, tx_valid, tx_last;

  int checks = 0, errors = 0, busy_seen = 0;
  bit finished = 0;
  logic [7:0] model [128];
  logic [7:0] m_flen = 0;
  bit m_lock = 0;

  always #2.5 clk = ~clk;

  rfbuf_top u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int eff(input int idx, input bit fe);
    return fe ? 127 - idx : idx;
  endfunction

  task automatic hw(input int idx, input bit fe, input logic [7:0] d);
    @(negedge clk);
    host_en = 1; host_we = 1; host_from_end = fe;
    host_idx = 7'(idx); host_wdata = d;
    #1;
    while (host_busy) begin busy_seen++; @(negedge clk); #1; end
    model[eff(idx, fe)] = d;
    @(posedge clk); #1;
    host_en = 0;
  endtask

  task automatic hr(input int idx, input bit fe, output logic [7:0] d);
    @(negedge clk);
    host_en = 1; host_we = 0; host_from_end = fe; host_idx = 7'(idx);
    #1;
    while (host_busy) begin busy_seen++; @(negedge clk); #1; end
    @(posedge clk); #1;
    host_en = 0;
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic check_all(input string req);
    logic [7:0] d;
    for (int i = 0; i < 128; i++) begin
      hr(i, 1'b0, d);
      chk(d === model[i], req, d, model[i]);
    end
  endtask

  // Receives one frame; models storage, truncation and lock.
  task automatic rx_frame(input int len, input int gapmax, input logic [7:0] q);
    int lim, wp;
    bit drop;
    lim = (len > 127) ? 127 : len;
    wp = 0;
    drop = m_lock && prot_en;
    @(negedge clk);
    rx_sof = 1; rx_len = 8'(len);
    if (!drop) m_flen = 8'(len);
    @(negedge clk);
    rx_sof = 0;
    for (int i = 0; i < len; i++) begin
      repeat ($urandom_range(gapmax)) @(negedge clk);
      rx_valid = 1; rx_data = 8'($urandom);
      if (!drop && wp < lim) begin model[wp] = rx_data; wp++; end
      @(negedge clk);
      rx_valid = 0;
    end
    rx_lqi_valid = 1; rx_lqi = q;
    if (!drop) begin
      model[wp] = q;
      if (prot_en) m_lock = 1;
    end
    @(negedge clk);
    rx_lqi_valid = 0;
    if (!drop) chk(rx_done === 1'b1, "R5 done pulse", rx_done, 1);
    @(negedge clk);
    chk(rx_done === 1'b0, "R5 done width", rx_done, 0);
  endtask

  task automatic tx_check(input string req);
    int L, k;
    bit got_last, done;
    L = (model[0] > 127) ? 127 : int'(model[0]);
    k = 0; got_last = 0; done = 0;
    @(negedge clk);
    tx_go = 1;
    @(negedge clk);
    tx_go = 0;
    chk(tx_busy === 1'b1, {req, " busy"}, tx_busy, 1);
    for (int c = 0; c < 400 && !done; c++) begin
      if (tx_valid) begin
        chk(tx_data === model[(k + 1) % 128], {req, " byte"}, tx_data, model[(k + 1) % 128]);
        k++;
        if (tx_last) begin got_last = 1; done = 1; end
      end else if (!tx_busy) done = 1;
      if (!done) @(negedge clk);
    end
    chk(k == L, {req, " count"}, k, L);
    chk(got_last == (L > 0), {req, " last"}, got_last, L > 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd4711));
    rst_n = 0; host_en = 0; host_we = 0; host_from_end = 0; host_idx = 0;
    host_wdata = 0; rx_sof = 0; rx_len = 0; rx_valid = 0; rx_data = 0;
    rx_lqi_valid = 0; rx_lqi = 0; prot_en = 0; prot_clr = 0; tx_go = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1
    chk({host_busy, tx_busy, tx_valid, rx_active, rx_done, rx_locked,
         rx_overrun, rx_len_err} === 8'h0, "R1 flags", {host_busy, tx_busy,
         tx_valid, rx_active, rx_done, rx_locked, rx_overrun, rx_len_err}, 0);
    chk(rx_frame_len === 8'h0 && host_rdata === 8'h0, "R1 regs", rx_frame_len, 0);

    // R2, R3: fill from start, read back from end
    for (int i = 0; i < 128; i++) hw(i, 1'b0, 8'($urandom));
    for (int i = 0; i < 128; i += 3) begin
      hr(i, 1'b1, d);
      chk(d === model[127 - i], "R3 from end", d, model[127 - i]);
    end
    hw(5, 1'b1, 8'hA5);
    hr(122, 1'b0, d);
    chk(d === 8'hA5, "R3 end write", d, 8'hA5);
    repeat (3) @(negedge clk);
    chk(host_rdata === 8'hA5, "R2 rdata hold", host_rdata, 8'hA5);

    // R4, R5: normal receive
    fork
      rx_frame(20, 2, 8'h3C);
      begin
        @(negedge clk); @(negedge clk); #1;
        chk(rx_active === 1'b1, "R4 active", rx_active, 1);
      end
    join
    chk(rx_frame_len === 8'd20, "R4 frame len", rx_frame_len, 20);
    chk(rx_active === 1'b0 && rx_len_err === 1'b0, "R4 idle", rx_active, 0);
    check_all("R4 R5 contents");

    // R9, R10: transmit frame
    hw(0, 1'b0, 8'd30);
    for (int i = 1; i <= 30; i++) hw(i, 1'b0, 8'($urandom));
    tx_check("R9 tx30");
    check_all("R10 after tx");
    hw(0, 1'b0, 8'd0);
    tx_check("R9 tx0");
    hw(0, 1'b0, 8'd200);
    tx_check("R9 tx capped");

    // R6: truncation
    rx_frame(140, 0, 8'h77);
    chk(rx_len_err === 1'b1, "R6 len err", rx_len_err, 1);
    chk(rx_frame_len === 8'd140, "R6 frame len", rx_frame_len, 140);
    hr(127, 1'b0, d);
    chk(d === 8'h77, "R6 lqi at end", d, 8'h77);
    check_all("R6 contents");
    rx_frame(127, 0, 8'h12);
    chk(rx_len_err === 1'b0, "R6 127 ok", rx_len_err, 0);
    hr(0, 1'b1, d);
    chk(d === 8'h12, "R6 lqi at 127", d, 8'h12);

    // R7: protection
    prot_en = 1;
    rx_frame(10, 1, 8'h55);
    chk(rx_locked === 1'b1, "R7 locked", rx_locked, 1);
    rx_frame(25, 1, 8'h66);
    chk(rx_overrun === 1'b1, "R7 overrun", rx_overrun, 1);
    chk(rx_frame_len === 8'd10, "R7 len kept", rx_frame_len, 10);
    check_all("R7 no overwrite");
    @(negedge clk); prot_clr = 1; @(negedge clk); prot_clr = 0; m_lock = 0;
    chk(rx_locked === 1'b0 && rx_overrun === 1'b0, "R7 clear", rx_overrun, 0);
    prot_en = 0;
    rx_frame(8, 1, 8'h99);
    chk(rx_frame_len === 8'd8, "R7 accepted after clear", rx_frame_len, 8);
    check_all("R7 new frame");

    // R8: receive against host writes
    busy_seen = 0;
    fork
      rx_frame(60, 1, 8'hE1);
      for (int i = 0; i < 40; i++) hw($urandom_range(127), 1'($urandom), 8'($urandom));
    join
    chk(busy_seen > 0, "R8 busy seen", busy_seen, 1);
    check_all("R8 contents");

    // Random mix
    for (int it = 0; it < 12; it++) begin
      case ($urandom_range(2))
        0: rx_frame($urandom_range(127), 1, 8'($urandom));
        1: begin
          hw(0, 1'b0, 8'($urandom_range(40)));
          tx_check("R9 random tx");
        end
        default: for (int j = 0; j < 10; j++)
          hw($urandom_range(127), 1'($urandom), 8'($urandom));
      endcase
      chk(rx_frame_len === m_flen, "R4 random len", rx_frame_len, m_flen);
    end
    check_all("R10 random contents");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule